// File: doc/BRIEF.md
# Interleaved Memory Block-Fill Engine

This block is a timing-accurate main-memory model paired with the controller that returns one four-word cache block after a miss. A requester presents a byte address with a single-cycle request strobe while the engine is idle. The engine spends one cycle sending the address, then runs 15-cycle memory accesses and 1-cycle bus transfers until all four words of the aligned block have been delivered. Each word is announced by its own valid strobe on its own data lane, and a done pulse marks the final transfer.

The memory organization is fixed at elaboration by a parameter. One-word-wide memory reads and transfers a single word per access. Two-word-wide memory reads and transfers two words per access. Four-bank interleaved memory starts all four banks together and then shares a single bus, one bank per cycle, in ascending word order. Every memory word holds its own byte address, so the returned data identifies exactly which word was fetched.

Top module: `blkfill_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, done and all word strobes are 0.
- R2: Counting the cycle after the accepting clock edge as cycle 1, done is high in cycle 65 for one-word-wide, in cycle 33 for two-word-wide and in cycle 20 for interleaved organization.
- R3: Word w (0..3) is strobed in cycle 1+16*(w+1) when one-word-wide, in cycle 1+16*(w/2+1) (integer division) when two-word-wide, and in cycle 17+w when interleaved.
- R4: At most one word strobe is high in any cycle for the one-word-wide and interleaved organizations, and at most two for two-word-wide.
- R5: Lane w of the data output (bits 32*w+31 down to 32*w) carries, while its strobe is high, the value B+4*w, where B is the request address with its four low bits cleared, zero-extended to 32 bits.
- R6: Every word of a block is strobed exactly once per request.
- R7: A request raised while the engine is busy is ignored: the timing and data of the block in progress are unchanged.
- R8: Done is a one-cycle pulse that coincides with the final word strobe, and busy is low in the cycle after done.
- R9: Busy is high in every cycle from cycle 1 up to and including the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fill request, taken on a rising edge while idle |
| req_addr | input | ADDR_W | Byte address of the missing word |
| busy | output | 1 | A block fill is in progress |
| word_valid | output | BLOCK_WORDS | Per-word delivery strobes, bit w for word w |
| fill_data | output | BLOCK_WORDS*WORD_W | Word lanes, lane w for word w |
| done | output | 1 | Final transfer of the block |

## Verification
Every result is due at a fixed cycle counted from the edge that takes the request: word strobes at 17, 33, 49, 65 (one-word-wide), 17 and 33 (two-word-wide) or 17 to 20 (interleaved), with done on the last of these and busy from cycle 1 through it. The bench instantiates all three organizations on shared inputs, samples on the falling edge of each of cycles 1 to 66 after the request and compares every strobe, done, busy and data lane against a cycle-indexed expectation. A stray request in cycle 5 checks that the in-progress block keeps its address and schedule, and per-block strobe counts confirm each word arrives once.

// File: rtl/bfe_pkg.sv
package bfe_pkg;

    typedef enum logic [1:0] {
        ORG_ONE_WORD    = 2'd0,
        ORG_TWO_WORD    = 2'd1,
        ORG_INTERLEAVED = 2'd2
    } org_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADDR   = 2'd1,
        ST_ACCESS = 2'd2,
        ST_XFER   = 2'd3
    } fill_state_e;

    // Words read together in one access round.
    function automatic int grp_words(org_e org, int block_words);
        case (org)
            ORG_ONE_WORD: return 1;
            ORG_TWO_WORD: return 2;
            default:      return block_words;
        endcase
    endfunction

    // Words moved across the bus in one transfer cycle.
    function automatic int beat_words(org_e org);
        return (org == ORG_TWO_WORD) ? 2 : 1;
    endfunction

    function automatic int cnt_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bfe_bank.sv
module bfe_bank #(
    parameter int ADDR_W  = 16,
    parameter int WORD_W  = 32,
    parameter int ACC_CYC = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] word_addr,
    output logic              ready,
    output logic [WORD_W-1:0] data
);
    localparam int CW = $clog2(ACC_CYC + 1);

    logic [CW-1:0]     cnt_q;
    logic              loaded_q;
    logic [WORD_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            loaded_q <= 1'b0;
            data_q   <= '0;
        end else if (start) begin
            cnt_q    <= CW'(ACC_CYC - 1);
            loaded_q <= 1'b1;
            data_q   <= WORD_W'(word_addr);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign ready = loaded_q && (cnt_q == '0);
    assign data  = data_q;

    AST_BANK_WAITS: assert property (@(posedge clk) disable iff (rst)
        start |=> !ready); // R2

endmodule

// File: rtl/bfe_ctrl.sv
module bfe_ctrl
    import bfe_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int OFF_W   = 4,
    parameter int ROUNDS  = 1,
    parameter int BEATS   = 4,
    parameter int ACC_CYC = 15,
    parameter int RW      = 1,
    parameter int BW      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              banks_ready,
    output logic              bank_start,
    output logic              xfer,
    output logic              busy,
    output logic              done,
    output logic [RW-1:0]     round,
    output logic [BW-1:0]     beat,
    output logic [ADDR_W-1:0] base
);
    localparam int FILL_LAT = 1 + ROUNDS * (ACC_CYC + BEATS);
    localparam int LW       = $clog2(FILL_LAT + 2);

    fill_state_e       state_q;
    logic [RW-1:0]     round_q;
    logic [BW-1:0]     beat_q;
    logic [ADDR_W-1:0] base_q;
    logic              last_beat, last_round;

    assign last_beat  = (beat_q == BW'(BEATS - 1));
    assign last_round = (round_q == RW'(ROUNDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            round_q <= '0;
            beat_q  <= '0;
            base_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    base_q  <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                    state_q <= ST_ADDR;
                end
                ST_ADDR: begin
                    round_q <= '0;
                    state_q <= ST_ACCESS;
                end
                ST_ACCESS: if (banks_ready) begin
                    beat_q  <= '0;
                    state_q <= ST_XFER;
                end
                ST_XFER: begin
                    if (!last_beat) begin
                        beat_q <= beat_q + 1'b1;
                    end else if (last_round) begin
                        state_q <= ST_IDLE;
                    end else begin
                        round_q <= round_q + 1'b1;
                        state_q <= ST_ACCESS;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign bank_start = (state_q == ST_ADDR) ||
                        ((state_q == ST_XFER) && last_beat && !last_round);
    assign xfer  = (state_q == ST_XFER);
    assign busy  = (state_q != ST_IDLE);
    assign done  = xfer && last_beat && last_round;
    assign round = round_q;
    assign beat  = beat_q;
    assign base  = base_q;

    // Cycle count since acceptance, kept for the latency check only.
    logic [LW-1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)                              age_q <= '0;
        else if (state_q == ST_IDLE)          age_q <= req_valid ? LW'(1) : '0;
        else if (age_q != LW'(FILL_LAT + 1))  age_q <= age_q + 1'b1;
    end

    AST_FILL_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done |-> (age_q == LW'(FILL_LAT))); // R2
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R8
    AST_BASE_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(base_q)); // R7

endmodule

// File: rtl/blkfill_engine.sv
module blkfill_engine
    import bfe_pkg::*;
#(
    parameter org_e ORG         = ORG_INTERLEAVED,
    parameter int   ADDR_W      = 16,
    parameter int   WORD_W      = 32,
    parameter int   BLOCK_WORDS = 4,
    parameter int   ACC_CYC     = 15
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic [ADDR_W-1:0]             req_addr,
    output logic                          busy,
    output logic [BLOCK_WORDS-1:0]        word_valid,
    output logic [BLOCK_WORDS*WORD_W-1:0] fill_data,
    output logic                          done
);
    localparam int BYTES  = WORD_W / 8;
    localparam int OFF_W  = $clog2(BLOCK_WORDS * BYTES);
    localparam int G      = grp_words(ORG, BLOCK_WORDS);
    localparam int B      = beat_words(ORG);
    localparam int ROUNDS = BLOCK_WORDS / G;
    localparam int BEATS  = G / B;
    localparam int RW     = cnt_width(ROUNDS);
    localparam int BW     = cnt_width(BEATS);

    logic              bank_start, xfer, banks_ready;
    logic [RW-1:0]     round;
    logic [BW-1:0]     beat;
    logic [ADDR_W-1:0] base, round_base;
    logic [G-1:0]      bank_ready;
    logic [WORD_W-1:0] bank_data [G];

    bfe_ctrl #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ROUNDS(ROUNDS), .BEATS(BEATS),
        .ACC_CYC(ACC_CYC), .RW(RW), .BW(BW)
    ) u_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .banks_ready(banks_ready), .bank_start(bank_start), .xfer(xfer),
        .busy(busy), .done(done), .round(round), .beat(beat), .base(base)
    );

    // Next access round starts while round still shows the finishing one.
    always_comb begin
        if (xfer) round_base = base + ADDR_W'(round + 1'b1) * ADDR_W'(G * BYTES);
        else      round_base = base;
    end

    assign banks_ready = &bank_ready;

    for (genvar g = 0; g < G; g++) begin : g_bank
        bfe_bank #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .ACC_CYC(ACC_CYC)) u_bank (
            .clk(clk), .rst(rst), .start(bank_start),
            .word_addr(round_base + ADDR_W'(g * BYTES)),
            .ready(bank_ready[g]), .data(bank_data[g])
        );
    end

    for (genvar w = 0; w < BLOCK_WORDS; w++) begin : g_lane
        localparam int LANE_G = w % G;
        localparam int LANE_R = w / G;
        localparam int LANE_B = LANE_G / B;
        assign word_valid[w] = xfer && (round == RW'(LANE_R)) && (beat == BW'(LANE_B));
        assign fill_data[w*WORD_W +: WORD_W] = word_valid[w] ? bank_data[LANE_G] : '0;

        AST_LANE_DATA: assert property (@(posedge clk) disable iff (rst)
            word_valid[w] |-> (fill_data[w*WORD_W +: WORD_W] ==
                               WORD_W'(base) + WORD_W'(w * BYTES))); // R5
    end

    AST_BUS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $countones(word_valid) <= B); // R4
    AST_STROBE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (word_valid != '0) |-> busy); // R9

endmodule

// File: tb/blkfill_engine_tb.sv
module blkfill_engine_tb;
    import bfe_pkg::*;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [15:0]  req_addr = '0;

    logic         busy_i, busy_o, busy_t, done_i, done_o, done_t;
    logic [3:0]   vld_i, vld_o, vld_t;
    logic [127:0] dat_i, dat_o, dat_t;

    int checks = 0;
    int errors = 0;
    int seen [3][4];

    always #2.5 clk = ~clk;

    blkfill_engine u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .busy(busy_i), .word_valid(vld_i), .fill_data(dat_i), .done(done_i));
    blkfill_engine #(.ORG(ORG_ONE_WORD)) u_dut_one (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .busy(busy_o), .word_valid(vld_o), .fill_data(dat_o), .done(done_o));
    blkfill_engine #(.ORG(ORG_TWO_WORD)) u_dut_two (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .busy(busy_t), .word_valid(vld_t), .fill_data(dat_t), .done(done_t));

    function automatic int exp_lat(int org);
        return (org == 0) ? 65 : (org == 1) ? 33 : 20;
    endfunction

    function automatic logic [3:0] exp_vld(int org, int k);
        logic [3:0] v = '0;
        for (int w = 0; w < 4; w++) begin
            if (org == 0 && k == 1 + 16 * (w + 1))     v[w] = 1'b1;
            if (org == 1 && k == 1 + 16 * (w / 2 + 1)) v[w] = 1'b1;
            if (org == 2 && k == 17 + w)               v[w] = 1'b1;
        end
        return v;
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_dut(int org, int k, logic [15:0] addr, logic b,
                             logic [3:0] v, logic d, logic [127:0] data);
        logic [3:0]  ev = exp_vld(org, k);
        logic [31:0] blk = {16'h0, addr[15:4], 4'h0};
        check(v == ev, $sformatf("R3 org%0d cycle%0d strobes", org, k), v, ev);
        check(d == (k == exp_lat(org)), $sformatf("R2 R8 org%0d cycle%0d done", org, k),
              d, k == exp_lat(org));
        check(b == (k <= exp_lat(org)), $sformatf("R9 org%0d cycle%0d busy", org, k),
              b, k <= exp_lat(org));
        for (int w = 0; w < 4; w++) begin
            if (v[w]) seen[org][w]++;
            if (ev[w])
                check(data[w*32 +: 32] == blk + 32'(4 * w),
                      $sformatf("R5 org%0d word%0d data", org, w),
                      data[w*32 +: 32], blk + 32'(4 * w));
        end
    endtask

    task automatic run_block(logic [15:0] addr, bit stray);
        for (int o = 0; o < 3; o++)
            for (int w = 0; w < 4; w++) seen[o][w] = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        @(negedge clk);
        for (int k = 1; k <= 66; k++) begin
            check_dut(0, k, addr, busy_o, vld_o, done_o, dat_o);
            check_dut(1, k, addr, busy_t, vld_t, done_t, dat_t);
            check_dut(2, k, addr, busy_i, vld_i, done_i, dat_i);
            if (k == 5 && stray) begin   // R7: request while busy
                req_valid = 1'b1;
                req_addr  = addr ^ 16'h5A50;
            end else begin
                req_valid = 1'b0;
                req_addr  = addr;
            end
            @(negedge clk);
        end
        for (int o = 0; o < 3; o++)
            for (int w = 0; w < 4; w++)
                check(seen[o][w] == 1, $sformatf("R6 R7 org%0d word%0d strobe count", o, w),
                      seen[o][w], 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy_i && !busy_o && !busy_t, "R1 busy in reset", busy_i, 0);
        check(vld_i == 0 && vld_o == 0 && vld_t == 0, "R1 strobes in reset", vld_i, 0);
        check(!done_i && !done_o && !done_t, "R1 done in reset", done_i, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_i && !busy_o && !busy_t && vld_i == 0 && vld_o == 0 && vld_t == 0,
              "R1 idle after reset", busy_i, 0);

        run_block(16'h0000, 1'b0);
        run_block(16'hFFFF, 1'b0);
        run_block(16'h1237, 1'b1);
        run_block(16'h8008, 1'b1);
        for (int i = 0; i < 6; i++) begin
            logic [15:0] a = 16'($urandom);
            bit s = 1'($urandom);
            repeat ($urandom % 3) @(negedge clk);
            run_block(a, s);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule